// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block is one parallel I/O port of eight pins. Software sees four byte-wide registers through a simple write-strobe and combinational-read interface. The registers are a data latch, a drive-enable mask, a sense-enable mask and a pullup mask. Toward the pad ring the block drives per-pin output data, output enable and pullup control. It also takes in the raw pad levels and passes them through a two-flop synchronizer.

Each pin has three possible owners, ranked from highest to lowest: an analog select, a peripheral takeover, and the port's own registers. The block works out the owner of every pin in every cycle and shapes the pad controls to match. It also builds the value returned when the data register is read. That value depends on the pin's sense-enable and drive-enable bits and on whether analog owns the pin. Peripheral ownership does not change what a read returns.

The register interface has no handshake. A write takes effect on the rising edge where `wr_en` is high. `rd_data` always shows the register selected by `addr`.

Top module: `gpio_port`

## Requirements
- R1: After reset, all four registers read 0x00, `pad_oe` is 0x00 and `pad_pu` is 0x00, so every pin is high-impedance.
- R2: A pin with sense-enable 1 and drive-enable 0 reads, at data offset 0, the pad level. The pad level is sampled through two flops, so a change at `pad_in` appears on the read after two rising edges and not after one.
- R3: A pin with sense-enable 0 reads, at offset 0, the last value written to the data register.
- R4: A pin with both sense-enable and drive-enable set reads, at offset 0, the data-register value and not the pad level.
- R5: When `per_own` is 1 for a pin, that pin's `pad_oe` equals `per_oe` and its `pad_out` equals `per_out`. Its read value at offset 0 still follows the port's own enable bits.
- R6: When `ana_sel` is 1 for a pin, that pin's `pad_oe`, `pad_out` and `pad_pu` are 0 and its read value at offset 0 is 0. This holds even when `per_own` is also 1 for that pin.
- R7: `pad_pu` is 1 only when the pin's pullup bit is 1, its `pad_oe` is 0 and `ana_sel` is 0.
- R8: `pad_oe` is set only by the pin's drive-enable bit, or by `per_oe` while the peripheral owns the pin. Writing the data register while drive-enable is 0 leaves `pad_oe` at 0.
- R9: The drive-enable register (offset 1), the sense-enable register (offset 2) and the pullup register (offset 3) read back exactly the last value written. They change only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 2 | Register select: 0 data, 1 drive-enable, 2 sense-enable, 3 pullup |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read of the register selected by addr |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Output data to pads |
| pad_oe | output | 8 | Output-driver enable to pads |
| pad_pu | output | 8 | Pullup enable to pads |
| per_own | input | 8 | Per-pin peripheral takeover |
| per_oe | input | 8 | Peripheral direction, 1 drives |
| per_out | input | 8 | Peripheral output data |
| ana_sel | input | 8 | Per-pin analog select |

## Verification
A write to the data register and a change of the pad level can fall in the same cycle. The two then compete for the offset-0 read on pins whose sense-enable is split. The bench provokes this by setting sense-enable on the low nibble only, then changing `pad_in` and writing new data on the same edge. One edge later the low nibble must still show the old synchronized level while the high nibble shows the new data. After the second edge both nibbles are compared again. In a separate test, analog select and peripheral ownership are asserted together on the same pins, and the pad controls are expected to follow the analog rule.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PINS   = 8;
  localparam int unsigned AW     = 2;

  typedef enum logic [AW-1:0] {
    REG_DATA  = 2'd0,
    REG_DRIVE = 2'd1,
    REG_SENSE = 2'd2,
    REG_PULL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wr_data,
  input  logic [W-1:0]  port_view,
  output logic [W-1:0]  data_q,
  output logic [W-1:0]  drive_q,
  output logic [W-1:0]  sense_q,
  output logic [W-1:0]  pull_q,
  output logic [W-1:0]  rd_data
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      drive_q <= '0;
      sense_q <= '0;
      pull_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        REG_DATA:  data_q  <= wr_data;
        REG_DRIVE: drive_q <= wr_data;
        REG_SENSE: sense_q <= wr_data;
        REG_PULL:  pull_q  <= wr_data;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      REG_DATA:  rd_data = port_view;
      REG_DRIVE: rd_data = drive_q;
      REG_SENSE: rd_data = sense_q;
      REG_PULL:  rd_data = pull_q;
      default:   rd_data = '0;
    endcase
  end

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(drive_q) && $stable(sense_q) && $stable(pull_q))); // R9
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
  input  logic ana,
  input  logic own,
  input  logic p_oe,
  input  logic p_out,
  input  logic r_data,
  input  logic r_drive,
  input  logic r_sense,
  input  logic r_pull,
  input  logic pin_sync,
  output logic o_out,
  output logic o_oe,
  output logic o_pu,
  output logic o_view
);
  logic digital_oe;
  logic digital_out;
  logic from_pad;

  always_comb begin
    if (own) begin
      digital_oe  = p_oe;
      digital_out = p_out;
    end else begin
      digital_oe  = r_drive;
      digital_out = r_data;
    end
  end

  assign o_oe  = ana ? 1'b0 : digital_oe;
  assign o_out = ana ? 1'b0 : digital_out;
  assign o_pu  = r_pull & ~ana & ~digital_oe;

  assign from_pad = r_sense & ~r_drive;
  assign o_view   = ana ? 1'b0 : (from_pad ? pin_sync : r_data);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W = PINS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu,
  input  logic [W-1:0]  per_own,
  input  logic [W-1:0]  per_oe,
  input  logic [W-1:0]  per_out,
  input  logic [W-1:0]  ana_sel
);
  logic [W-1:0] data_q, drive_q, sense_q, pull_q;
  logic [W-1:0] pin_sync;
  logic [W-1:0] port_view;

  gpio_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .port_view (port_view),
    .data_q    (data_q),
    .drive_q   (drive_q),
    .sense_q   (sense_q),
    .pull_q    (pull_q),
    .rd_data   (rd_data)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    gpio_pin_mux u_mux (
      .ana      (ana_sel[i]),
      .own      (per_own[i]),
      .p_oe     (per_oe[i]),
      .p_out    (per_out[i]),
      .r_data   (data_q[i]),
      .r_drive  (drive_q[i]),
      .r_sense  (sense_q[i]),
      .r_pull   (pull_q[i]),
      .pin_sync (pin_sync[i]),
      .o_out    (pad_out[i]),
      .o_oe     (pad_oe[i]),
      .o_pu     (pad_pu[i]),
      .o_view   (port_view[i])
    );
  end

  AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out | pad_pu) & ana_sel) == '0); // R6
  AST_ANALOG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == REG_DATA) |-> ((rd_data & ana_sel) == '0)); // R6
  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0); // R7
  AST_DRIVE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~((drive_q & ~per_own) | (per_oe & per_own))) == '0); // R8
  AST_PERIPH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ per_oe) & per_own & ~ana_sel) == '0); // R5
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pad_pu;
  logic [7:0] per_own = '0, per_oe = '0, per_out = '0, ana_sel = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .per_own(per_own), .per_oe(per_oe), .per_out(per_out),
    .ana_sel(ana_sel)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic clear_all();
    per_own = '0; per_oe = '0; per_out = '0; ana_sel = '0;
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd0, 8'h00);
  endtask

  task automatic test_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1", "reset register", v, 8'h00);
    end
    check("R1", "reset pad_oe", pad_oe, 8'h00);
    check("R1", "reset pad_pu", pad_pu, 8'h00);
  endtask

  task automatic test_write_no_drive();
    wr(2'd0, 8'hFF);
    #1;
    check("R8", "pad_oe after data write with drive off", pad_oe, 8'h00);
    wr(2'd1, 8'h0F);
    #1;
    check("R8", "pad_oe follows drive bits", pad_oe, 8'h0F);
    check("R8", "pad_out shows latched data", pad_out, 8'hFF);
    clear_all();
  endtask

  task automatic test_input_read();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hFF);
    @(negedge clk);
    pad_in = 8'hC3;
    @(negedge clk);
    rd(2'd0, v);
    check("R2", "one edge after pad change", v, 8'h00);
    @(negedge clk);
    rd(2'd0, v);
    check("R2", "two edges after pad change", v, 8'hC3);
    pad_in = 8'h00;
    clear_all();
  endtask

  task automatic test_latch_read();
    logic [7:0] v;
    pad_in = 8'hFF;
    wr(2'd0, 8'h5A);
    repeat (2) @(negedge clk);
    rd(2'd0, v);
    check("R3", "sense off returns written data", v, 8'h5A);
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'hFF);
    rd(2'd0, v);
    check("R4", "sense and drive both set return data", v, 8'h5A);
    pad_in = 8'h00;
    clear_all();
  endtask

  task automatic test_same_cycle();
    logic [7:0] v;
    wr(2'd2, 8'h0F);
    @(negedge clk);
    pad_in = 8'hA5;
    wr_en = 1'b1; addr = 2'd0; wr_data = 8'h3C;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd0, v);
    check("R2", "split nibble after one edge", v, 8'h30);
    @(negedge clk);
    rd(2'd0, v);
    check("R3", "split nibble after two edges", v, 8'h35);
    pad_in = 8'h00;
    clear_all();
  endtask

  task automatic test_periph_analog();
    logic [7:0] v;
    wr(2'd0, 8'h55);
    wr(2'd1, 8'hFF);
    @(negedge clk);
    per_own = 8'h0F; per_oe = 8'h05; per_out = 8'h0A;
    #1;
    check("R5", "pad_oe with peripheral", pad_oe, 8'hF5);
    check("R5", "pad_out with peripheral", pad_out, 8'h5A);
    rd(2'd0, v);
    check("R5", "read ignores peripheral", v, 8'h55);
    @(negedge clk);
    ana_sel = 8'h03;
    #1;
    check("R6", "pad_oe analog over peripheral", pad_oe, 8'hF4);
    check("R6", "pad_out analog zeroed", pad_out, 8'h58);
    rd(2'd0, v);
    check("R6", "analog bits read zero", v, 8'h54);
    clear_all();
  endtask

  task automatic test_pullup();
    wr(2'd3, 8'hFF);
    wr(2'd1, 8'h0F);
    @(negedge clk);
    per_own = 8'h30; per_oe = 8'h10; ana_sel = 8'h80;
    #1;
    check("R7", "pad_oe mixed owners", pad_oe, 8'h1F);
    check("R7", "pullup only on undriven digital pins", pad_pu, 8'h60);
    clear_all();
  endtask

  task automatic test_cfg_readback();
    logic [7:0] v;
    wr(2'd1, 8'h96);
    wr(2'd2, 8'h69);
    wr(2'd3, 8'hE1);
    wr(2'd0, 8'h00);
    rd(2'd1, v); check("R9", "drive readback", v, 8'h96);
    rd(2'd2, v); check("R9", "sense readback", v, 8'h69);
    rd(2'd3, v); check("R9", "pull readback", v, 8'hE1);
    clear_all();
  endtask

  initial begin
    #20;
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_write_no_drive();
    test_input_read();
    test_latch_read();
    test_same_cycle();
    test_periph_analog();
    test_pullup();
    test_cfg_readback();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule